// File: doc/BRIEF.md
# Eight-Bit Timer with Compare Waveform Output

This block is an 8-bit timer-counter with one compare channel that drives a single waveform output. Software programs it through a small register port with four addresses: control, count, compare and flags. The control register chooses one of four counting modes, how the waveform output reacts to compare events, and where the count clock comes from. That source can be the system clock, one of four prescaler divisions, or an edge of an external enable input.

The two PWM modes keep a second copy of the compare value, and the copy reaches the comparator only at a fixed point in the count period. This keeps each period free of glitches. A one-shot force bit lets software apply a compare action to the waveform without a real match. An override-enable output tells the surrounding pin logic to take over the I/O pin whenever waveform output is enabled.

The counter advances only on a timer tick. All other state changes only on bus writes. The bus read data is combinational from the registers.

Top module: `tmr8_wavegen`

## Requirements
- R1: After reset, the control, count, compare and flag registers read 0, and `wave_out` and `wave_oe` are 0.
- R2: The register addresses are 0 control, 1 count, 2 compare and 3 flags. Control bit 7 is the force strobe and always reads back 0. Bit 6 is mode bit 0, bits 5:4 are the output action, bit 3 is mode bit 1, and bits 2:0 are the clock source. The mode {bit3,bit6} is 00 free-run, 01 up/down PWM, 10 clear-on-match and 11 single-slope PWM.
- R3: In free-run mode each tick adds 1 and wraps from 0xFF to 0. A tick taken while the count is 0xFF sets the overflow flag (flags bit 0).
- R4: In clear-on-match mode, a tick that finds a compare match loads the count with 0, so the compare value is the top of the period. The overflow flag is still set by a tick at 0xFF.
- R5: In single-slope PWM the count wraps at 0xFF, and a tick at 0xFF sets overflow. With action 10 the output is cleared on a match and set on the wrap to 0. Action 11 does the opposite. The wrap action wins when both happen on the same tick.
- R6: In up/down PWM the count rises to 0xFF, then falls to 0, then rises again. A tick taken at 0 sets overflow. With action 10 a match clears the output while rising and sets it while falling. Action 11 does the opposite.
- R7: A compare write takes effect at once in free-run and clear-on-match modes. In both PWM modes it goes only to a buffer, which is copied to the active compare value on the tick taken at 0xFF. The compare address reads back the buffer.
- R8: A tick that finds the count equal to the active compare value sets the match flag (flags bit 1).
- R9: In free-run and clear-on-match modes a match applies the output action: 01 toggles, 10 clears, 11 sets, and 00 does nothing.
- R10: Writing control with bit 7 set in a non-PWM mode applies the R9 action, using the newly written action bits. It does not set the match flag and does not change the count. In the PWM modes the strobe has no effect.
- R11: `wave_oe` is 1 exactly when the output action bits are nonzero.
- R12: The clock source codes are 000 stopped, 001 every cycle, and 010 to 101 every 8, 64, 256 and 1024 cycles. Code 110 ticks on a falling edge of `ext_clk_in` and code 111 on a rising edge.
- R13: A count write takes priority over a tick in the same cycle. The first tick after a count write produces no compare match.
- R14: Writing 1 to a flag bit clears it, and writing 0 leaves it. If an event occurs in the same cycle as the clear, the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| ext_clk_in | input | 1 | External count enable, edge-detected |
| wave_out | output | 1 | Compare waveform |
| wave_oe | output | 1 | Pin override enable |
| ovf_flag | output | 1 | Overflow flag |
| cmp_flag | output | 1 | Compare-match flag |

## Verification
The bench aims at the places where the period ends:
- A design that wraps clear-on-match at 0xFF, or that turns up/down PWM around at the wrong value, ends on a count different from the one expected.
- A design that sets overflow at the wrong end of the up/down period shows the wrong flag.

The compare buffer is tested by running past the old compare value before and after the load point. A design that updates the compare value at once in PWM modes matches at the wrong count.

The force strobe is checked for three things. It must not raise the match flag. It must not clear the count in clear-on-match mode. It must be ignored in PWM mode.

The count-write block is checked by writing the compare value into the count while the timer runs. A design without the block would raise a match on the next tick.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
  typedef enum logic [1:0] {
    MD_NORMAL = 2'b00,
    MD_PCPWM  = 2'b01,
    MD_CTC    = 2'b10,
    MD_FAST   = 2'b11
  } tmr_mode_e;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_CNT  = 2'd1;
  localparam logic [1:0] A_CMP  = 2'd2;
  localparam logic [1:0] A_FLG  = 2'd3;

  localparam logic [2:0] CS_STOP = 3'd0;
  localparam logic [2:0] CS_DIV1 = 3'd1;
  localparam logic [2:0] CS_DIV8 = 3'd2;
  localparam logic [2:0] CS_D64  = 3'd3;
  localparam logic [2:0] CS_D256 = 3'd4;
  localparam logic [2:0] CS_D1K  = 3'd5;
  localparam logic [2:0] CS_EXTF = 3'd6;
  localparam logic [2:0] CS_EXTR = 3'd7;
endpackage

// File: rtl/tmr8_prescale.sv
module tmr8_prescale
  import tmr8_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] clk_sel,
  input  logic       ext_in,
  output logic       tick
);
  localparam int TAP8 = 3;
  localparam int TAP64 = 6;
  localparam int TAP256 = 8;
  localparam int TAP1K = 10;

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [2:0]       ext_q, ext_d;
  logic             ext_rise, ext_fall;

  always_comb begin
    pre_d = pre_q + 1'b1;
    ext_d = {ext_q[1:0], ext_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ext_q <= '0;
    end else begin
      pre_q <= pre_d;
      ext_q <= ext_d;
    end
  end

  assign ext_rise = ext_q[1] & ~ext_q[2];
  assign ext_fall = ~ext_q[1] & ext_q[2];

  always_comb begin
    case (clk_sel)
      CS_STOP: tick = 1'b0;
      CS_DIV1: tick = 1'b1;
      CS_DIV8: tick = &pre_q[TAP8-1:0];
      CS_D64:  tick = &pre_q[TAP64-1:0];
      CS_D256: tick = &pre_q[TAP256-1:0];
      CS_D1K:  tick = &pre_q[TAP1K-1:0];
      CS_EXTF: tick = ext_fall;
      default: tick = ext_rise;
    endcase
  end

  // R12: a stopped source never produces a tick
  p_stop_no_tick_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == CS_STOP) |-> !tick);
endmodule

// File: rtl/tmr8_count.sv
module tmr8_count
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  tmr_mode_e        mode,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wval,
  input  logic [CNT_W-1:0] ocr_act,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_down,
  output logic             match,
  output logic             ovf_evt,
  output logic             wrap_evt
);
  localparam logic [CNT_W-1:0] MAXV = '1;
  localparam logic [CNT_W-1:0] BOTV = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dir_q, dir_d;
  logic             blk_q, blk_d;
  logic             adv;

  assign adv      = tick & ~cnt_we;
  assign match    = adv & ~blk_q & (cnt_q == ocr_act);
  assign ovf_evt  = adv & ((mode == MD_PCPWM) ? (cnt_q == BOTV) : (cnt_q == MAXV));
  assign wrap_evt = adv & (cnt_q == MAXV) & ((mode == MD_PCPWM) | (mode == MD_FAST));

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    blk_d = blk_q;
    if (cnt_we) begin
      cnt_d = cnt_wval;
      blk_d = 1'b1;
    end else if (tick) begin
      blk_d = 1'b0;
      case (mode)
        MD_CTC: cnt_d = match ? BOTV : cnt_q + 1'b1;
        MD_PCPWM: begin
          if (!dir_q) begin
            if (cnt_q == MAXV) begin
              dir_d = 1'b1;
              cnt_d = cnt_q - 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end else begin
            if (cnt_q == BOTV) begin
              dir_d = 1'b0;
              cnt_d = cnt_q + 1'b1;
            end else begin
              cnt_d = cnt_q - 1'b1;
            end
          end
        end
        default: cnt_d = cnt_q + 1'b1;
      endcase
    end
    if (mode != MD_PCPWM) dir_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b0;
      blk_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
      blk_q <= blk_d;
    end
  end

  assign cnt      = cnt_q;
  assign dir_down = dir_q;

  // R4: a real match in clear-on-match mode empties the counter
  p_ctc_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_CTC && match) |=> (cnt_q == BOTV));
  // R12: with no tick and no write the count holds
  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_we) |=> $stable(cnt_q));
  // R13: the tick right after a count write never matches
  p_write_block_r13: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> !match);
endmodule

// File: rtl/tmr8_wave.sv
module tmr8_wave
  import tmr8_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tmr_mode_e mode,
  input  logic [1:0] com,
  input  logic      match,
  input  logic      wrap_evt,
  input  logic      dir_down,
  input  logic      force_ok,
  input  logic [1:0] force_com,
  output logic      wave
);
  logic wave_q, wave_d;

  function automatic logic step_act(input logic [1:0] c, input logic w);
    case (c)
      2'b01:   step_act = ~w;
      2'b10:   step_act = 1'b0;
      2'b11:   step_act = 1'b1;
      default: step_act = w;
    endcase
  endfunction

  always_comb begin
    wave_d = wave_q;
    if (force_ok) begin
      wave_d = step_act(force_com, wave_q);
    end else begin
      case (mode)
        MD_FAST: begin
          if (wrap_evt && com[1])   wave_d = ~com[0];
          else if (match && com[1]) wave_d = com[0];
        end
        MD_PCPWM: begin
          if (match && com[1]) wave_d = com[0] ^ dir_down;
        end
        default: begin
          if (match) wave_d = step_act(com, wave_q);
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else        wave_q <= wave_d;
  end

  assign wave = wave_q;

  // R5: wrap to zero with action 10 in single-slope PWM leaves the output high
  p_fast_bottom_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_FAST && com == 2'b10 && wrap_evt) |=> wave_q);
  // R9: action 00 keeps the output still when nothing is forced
  p_no_action_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (com == 2'b00 && !force_ok) |=> $stable(wave_q));
endmodule

// File: rtl/tmr8_wavegen.sv
module tmr8_wavegen
  import tmr8_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       bus_addr,
  input  logic             bus_wr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  input  logic             ext_clk_in,
  output logic             wave_out,
  output logic             wave_oe,
  output logic             ovf_flag,
  output logic             cmp_flag
);
  localparam int B_FRC = 7;
  localparam int B_M0  = 6;
  localparam int B_M1  = 3;

  logic [1:0]       rst_sq;
  logic             rst_ni;
  logic [6:0]       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] buf_q, buf_d, act_q, act_d;
  logic             ovf_q, ovf_d, cmpf_q, cmpf_d;
  logic             ctrl_we, cnt_we, cmp_we, flg_we;
  tmr_mode_e        mode, new_mode;
  logic [1:0]       com;
  logic             force_ok, tick, match, ovf_evt, wrap_evt, dir_down;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sq <= 2'b00;
    else        rst_sq <= {rst_sq[0], 1'b1};
  end
  assign rst_ni = rst_sq[1];

  assign ctrl_we  = bus_wr & (bus_addr == A_CTRL);
  assign cnt_we   = bus_wr & (bus_addr == A_CNT);
  assign cmp_we   = bus_wr & (bus_addr == A_CMP);
  assign flg_we   = bus_wr & (bus_addr == A_FLG);
  assign mode     = tmr_mode_e'({ctrl_q[B_M1], ctrl_q[B_M0]});
  assign com      = ctrl_q[5:4];
  assign new_mode = tmr_mode_e'({bus_wdata[B_M1], bus_wdata[B_M0]});
  assign force_ok = ctrl_we & bus_wdata[B_FRC] & ~new_mode[0];

  always_comb begin
    ctrl_d = ctrl_we ? bus_wdata[6:0] : ctrl_q;
    buf_d  = cmp_we ? bus_wdata : buf_q;
    act_d  = act_q;
    if (cmp_we && !mode[0]) act_d = bus_wdata;
    else if (wrap_evt)      act_d = buf_q;
    ovf_d  = ovf_q;
    cmpf_d = cmpf_q;
    if (flg_we && bus_wdata[0]) ovf_d  = 1'b0;
    if (flg_we && bus_wdata[1]) cmpf_d = 1'b0;
    if (ovf_evt) ovf_d  = 1'b1;
    if (match)   cmpf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      buf_q  <= '0;
      act_q  <= '0;
      ovf_q  <= 1'b0;
      cmpf_q <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      buf_q  <= buf_d;
      act_q  <= act_d;
      ovf_q  <= ovf_d;
      cmpf_q <= cmpf_d;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = {1'b0, ctrl_q};
      A_CNT:   bus_rdata = cnt;
      A_CMP:   bus_rdata = buf_q;
      default: bus_rdata = {{(CNT_W-2){1'b0}}, cmpf_q, ovf_q};
    endcase
  end

  tmr8_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst_n(rst_ni), .clk_sel(ctrl_q[2:0]), .ext_in(ext_clk_in), .tick(tick)
  );

  tmr8_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_ni), .tick(tick), .mode(mode), .cnt_we(cnt_we),
    .cnt_wval(bus_wdata), .ocr_act(act_q), .cnt(cnt), .dir_down(dir_down),
    .match(match), .ovf_evt(ovf_evt), .wrap_evt(wrap_evt)
  );

  tmr8_wave u_wave (
    .clk(clk), .rst_n(rst_ni), .mode(mode), .com(com), .match(match),
    .wrap_evt(wrap_evt), .dir_down(dir_down), .force_ok(force_ok),
    .force_com(bus_wdata[5:4]), .wave(wave_out)
  );

  assign wave_oe  = |com;
  assign ovf_flag = ovf_q;
  assign cmp_flag = cmpf_q;

  // R3: overflow event in free-run mode is visible in the flag next cycle
  p_normal_ovf_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode == MD_NORMAL && ovf_evt) |=> ovf_q);
  // R10: a force without a real match leaves the match flag alone
  p_force_no_flag_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (force_ok && !match) |=> $stable(cmpf_q));
  // R7: in PWM modes the active compare moves only at the load point
  p_buf_hold_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (mode[0] && !wrap_evt) |=> $stable(act_q));
endmodule

// File: tb/tb_tmr8_wavegen.sv
module tb_tmr8_wavegen;
  logic       clk;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic       ext_clk_in;
  logic       wave_out, wave_oe, ovf_flag, cmp_flag;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  tmr8_wavegen dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_clk_in(ext_clk_in),
    .wave_out(wave_out), .wave_oe(wave_oe), .ovf_flag(ovf_flag), .cmp_flag(cmp_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {mode[1:0], cmp[7:0], start[7:0], ticks[15:0], exp_cnt[7:0], exp_ovf, exp_cmp}
  localparam int NV = 7;
  localparam logic [43:0] VEC [NV] = '{
    {2'b00, 8'h10, 8'hF0, 16'd20,  8'h04, 1'b1, 1'b0},  // R3 wrap
    {2'b00, 8'h05, 8'h00, 16'd10,  8'h0A, 1'b0, 1'b1},  // R3 R8
    {2'b10, 8'h09, 8'h00, 16'd25,  8'h05, 1'b0, 1'b1},  // R4 period 10
    {2'b10, 8'h03, 8'hFE, 16'd3,   8'h01, 1'b1, 1'b0},  // R4 ovf at 0xFF
    {2'b11, 8'h40, 8'hFC, 16'd6,   8'h02, 1'b1, 1'b0},  // R5
    {2'b01, 8'h80, 8'hFD, 16'd5,   8'hFC, 1'b0, 1'b0},  // R6 turn at top
    {2'b01, 8'h80, 8'hFE, 16'd260, 8'h04, 1'b1, 1'b1}   // R6 ovf at bottom
  };

  function automatic logic [7:0] cw(input logic f, input logic [1:0] m,
                                    input logic [1:0] c, input logic [2:0] s);
    cw = {f, m[0], c, m[1], s};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  // start with ctrl value go, allow n ticks at div1, then write stop
  task automatic run(input logic [7:0] go, input logic [7:0] stop, input int n);
    wr(2'd0, go);
    repeat (n - 1) @(negedge clk);
    wr(2'd0, stop);
  endtask

  logic [7:0] r;

  initial begin
    bus_addr = 0; bus_wr = 0; bus_wdata = 0; ext_clk_in = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], r); chk("R1 reg", r, 8'h00);
    end
    chk("R1 wave_out", {7'b0, wave_out}, 8'h00);
    chk("R1 wave_oe", {7'b0, wave_oe}, 8'h00);

    // table of mode vectors
    for (int i = 0; i < NV; i++) begin
      logic [43:0] v;
      v = VEC[i];
      wr(2'd0, 8'h00);
      wr(2'd2, v[41:34]);
      wr(2'd1, v[33:26]);
      wr(2'd3, 8'h03);
      run(cw(0, v[43:42], 2'b00, 3'd1), cw(0, v[43:42], 2'b00, 3'd0), int'(v[25:10]));
      rd(2'd1, r); chk($sformatf("R3-R6 vec%0d count", i), r, v[9:2]);
      chk($sformatf("R3 R4 R5 R6 vec%0d ovf", i), {7'b0, ovf_flag}, {7'b0, v[1]});
      chk($sformatf("R8 vec%0d match", i), {7'b0, cmp_flag}, {7'b0, v[0]});
    end

    // R10 R2 force in clear-on-match mode
    wr(2'd0, 8'h00); wr(2'd1, 8'h33); wr(2'd3, 8'h03);
    wr(2'd0, cw(1, 2'b10, 2'b11, 3'd0));
    chk("R10 force set", {7'b0, wave_out}, 8'h01);
    chk("R10 no flag", {7'b0, cmp_flag}, 8'h00);
    rd(2'd1, r); chk("R10 count kept", r, 8'h33);
    rd(2'd0, r); chk("R2 force reads 0", r, cw(0, 2'b10, 2'b11, 3'd0));
    wr(2'd0, cw(1, 2'b10, 2'b10, 3'd0));
    chk("R9 R10 force clear", {7'b0, wave_out}, 8'h00);
    wr(2'd0, cw(1, 2'b00, 2'b01, 3'd0));
    chk("R9 R10 force toggle", {7'b0, wave_out}, 8'h01);
    wr(2'd0, cw(1, 2'b11, 2'b10, 3'd0));
    chk("R10 ignored in PWM", {7'b0, wave_out}, 8'h01);
    chk("R11 oe on", {7'b0, wave_oe}, 8'h01);
    wr(2'd0, 8'h00);
    chk("R11 oe off", {7'b0, wave_oe}, 8'h00);

    // R9 real match toggles in free-run
    wr(2'd2, 8'h03); wr(2'd1, 8'h01);
    run(cw(0, 2'b00, 2'b01, 3'd1), cw(0, 2'b00, 2'b01, 3'd0), 3);
    chk("R9 match toggle", {7'b0, wave_out}, 8'h00);

    // R5 single-slope PWM waveform
    wr(2'd0, 8'h00); wr(2'd2, 8'h80); wr(2'd1, 8'hFE);
    wr(2'd0, cw(1, 2'b00, 2'b10, 3'd0));
    run(cw(0, 2'b11, 2'b10, 3'd1), cw(0, 2'b11, 2'b10, 3'd0), 2);
    chk("R5 set at bottom", {7'b0, wave_out}, 8'h01);
    wr(2'd1, 8'h7F);
    run(cw(0, 2'b11, 2'b10, 3'd1), cw(0, 2'b11, 2'b10, 3'd0), 2);
    chk("R5 clear on match", {7'b0, wave_out}, 8'h00);

    // R6 up/down PWM: action 10 clears while rising
    wr(2'd0, 8'h00); wr(2'd2, 8'h03); wr(2'd1, 8'h01);
    wr(2'd0, cw(1, 2'b00, 2'b11, 3'd0));
    run(cw(0, 2'b01, 2'b10, 3'd1), cw(0, 2'b01, 2'b10, 3'd0), 3);
    chk("R6 clear rising", {7'b0, wave_out}, 8'h00);

    // R7 immediate in free-run
    wr(2'd0, 8'h00); wr(2'd2, 8'h30); wr(2'd1, 8'h2E); wr(2'd3, 8'h03);
    run(8'h01, 8'h00, 3);
    chk("R7 immediate", {7'b0, cmp_flag}, 8'h01);

    // R7 buffered in single-slope PWM
    wr(2'd0, 8'h00); wr(2'd2, 8'h10);
    wr(2'd0, cw(0, 2'b11, 2'b00, 3'd0)); wr(2'd2, 8'h20);
    rd(2'd2, r); chk("R7 readback buffer", r, 8'h20);
    wr(2'd1, 8'h0E); wr(2'd3, 8'h03);
    run(cw(0, 2'b11, 2'b00, 3'd1), cw(0, 2'b11, 2'b00, 3'd0), 3);
    chk("R7 old value active", {7'b0, cmp_flag}, 8'h01);
    wr(2'd1, 8'hFE); wr(2'd3, 8'h03);
    run(cw(0, 2'b11, 2'b00, 3'd1), cw(0, 2'b11, 2'b00, 3'd0), 19);
    chk("R7 loaded at wrap", {7'b0, cmp_flag}, 8'h00);
    rd(2'd1, r); chk("R7 count", r, 8'h11);

    // R7 buffered in up/down PWM
    wr(2'd0, 8'h00); wr(2'd2, 8'h10);
    wr(2'd0, cw(0, 2'b01, 2'b00, 3'd0)); wr(2'd2, 8'h50);
    wr(2'd1, 8'h0E); wr(2'd3, 8'h03);
    run(cw(0, 2'b01, 2'b00, 3'd1), cw(0, 2'b01, 2'b00, 3'd0), 3);
    chk("R7 up/down old value", {7'b0, cmp_flag}, 8'h01);

    // R13 count write blocks next match and wins over tick
    wr(2'd0, 8'h00); wr(2'd2, 8'h40); wr(2'd3, 8'h03);
    wr(2'd0, 8'h01); wr(2'd1, 8'h40); wr(2'd0, 8'h00);
    rd(2'd1, r); chk("R13 count", r, 8'h41);
    chk("R13 no match", {7'b0, cmp_flag}, 8'h00);

    // R12 stopped
    wr(2'd1, 8'h55);
    repeat (10) @(negedge clk);
    rd(2'd1, r); chk("R12 stopped", r, 8'h55);

    // R12 divide by 8
    wr(2'd1, 8'h00);
    run(cw(0, 2'b00, 2'b00, 3'd2), 8'h00, 16);
    rd(2'd1, r); chk("R12 div8", r, 8'h02);

    // R12 external rising and falling
    for (int e = 0; e < 2; e++) begin
      wr(2'd1, 8'h00);
      wr(2'd0, (e == 0) ? 8'h07 : 8'h06);
      repeat (3) begin
        ext_clk_in = 1'b1; repeat (3) @(negedge clk);
        ext_clk_in = 1'b0; repeat (3) @(negedge clk);
      end
      repeat (4) @(negedge clk);
      wr(2'd0, 8'h00);
      rd(2'd1, r); chk($sformatf("R12 external edge %0d", e), r, 8'h03);
    end

    // R14 write-one-to-clear per bit
    wr(2'd2, 8'h00); wr(2'd1, 8'hFE); wr(2'd3, 8'h03);
    run(8'h01, 8'h00, 3);
    rd(2'd3, r); chk("R14 both set", r, 8'h03);
    wr(2'd3, 8'h01);
    rd(2'd3, r); chk("R14 clear ovf only", r, 8'h02);
    wr(2'd3, 8'h02);
    rd(2'd3, r); chk("R14 clear match", r, 8'h00);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog R1-R14 run: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule